// File: doc/BRIEF.md
# Floating-Point Exception Status Logic

This block keeps the exception status of a floating-point unit. Each time an operation completes, the datapath presents five raw event bits (invalid operation, divide by zero, overflow, underflow, inexact) together with a one-cycle completion strobe. The block then rewrites two status fields in a single clock cycle.

The sticky-free flag field records every event the operation raised, whatever the enables say. The cause field records only the events whose enable bit is set. A trap request goes high whenever the new cause field is nonzero, so the pipeline can divert to its exception handler.

The enable field belongs to software. It changes only through its write port, and the status logic reads it but never alters it. All fields hold their values between operations.

Top module: `fpx_status_unit`

## Requirements
- R1: After reset the flag, cause and enable fields are zero and the trap request is low.
- R2: Every 5-bit field uses one bit position per class: bit 4 invalid, bit 3 divide by zero, bit 2 overflow, bit 1 underflow, bit 0 inexact. In the cycle after a completion strobe, the flag field equals the raw events presented with that strobe, regardless of the enable field.
- R3: In the cycle after a completion strobe, the cause field equals the raw events ANDed with the enable field.
- R4: A completion with no raw events writes zero into both the flag and the cause fields.
- R5: While the completion strobe is low, the flag and cause fields hold their values, and changes on the raw event inputs have no effect.
- R6: The trap request is high exactly when the cause field is nonzero. It changes in the same cycle as the cause field.
- R7: A software write loads the enable field in the next cycle. Without a write the enable field holds, and completions never modify it.
- R8: When a software write and a completion share a cycle, the cause uses the enable value held before that write. The new enable value appears in the next cycle.
- R9: Flags are overwritten, not accumulated. A class raised by one operation and not by the next reads zero after the second completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_done_i | input | 1 | Operation-complete strobe, one cycle per operation |
| raw_evt_i | input | 5 | Raw exception events of the completing operation |
| en_we_i | input | 1 | Software write strobe for the enable field |
| en_wdata_i | input | 5 | New enable field value |
| flags_o | output | 5 | Flag field |
| cause_o | output | 5 | Cause field |
| enables_o | output | 5 | Enable field |
| trap_req_o | output | 1 | Trap request, high while any enabled cause is set |

## Verification
Every status field is visible at the ports one cycle after the strobe that wrote it. A wrong flag, cause or enable bit therefore shows at the very next sample after the operation. A bit routed to the wrong class would appear only for patterns that separate the classes, so single-class patterns and mixed patterns against partial enable masks are both driven. A trap request that disagrees with the cause field, or state that leaks between operations, shows up at the first sample after the strobe that exposes it.

// File: rtl/fpx_pkg.sv
package fpx_pkg;

    localparam int unsigned FPX_NCLS = 5;

    typedef enum int unsigned {
        CLS_INEXACT   = 0,
        CLS_UNDERFLOW = 1,
        CLS_OVERFLOW  = 2,
        CLS_DIVZERO   = 3,
        CLS_INVALID   = 4
    } fpx_cls_e;

    typedef logic [FPX_NCLS-1:0] fpx_vec_t;

    typedef struct packed {
        fpx_vec_t flags;
        fpx_vec_t cause;
        fpx_vec_t enables;
        logic     trap;
    } fpx_state_t;

endpackage

// File: rtl/fpx_class_slice.sv
// One exception class: the flag follows the event, and the cause is the event gated by the enable.
module fpx_class_slice (
    input  logic evt_i,
    input  logic en_i,
    output logic flag_o,
    output logic cause_o
);
    always_comb begin
        flag_o  = evt_i;
        cause_o = evt_i & en_i;
    end
endmodule

// File: rtl/fpx_enable_next.sv
// Next value of the software-owned enable field.
module fpx_enable_next #(
    parameter int unsigned WIDTH = 5
) (
    input  logic             we_i,
    input  logic [WIDTH-1:0] wdata_i,
    input  logic [WIDTH-1:0] cur_i,
    output logic [WIDTH-1:0] next_o
);
    always_comb begin
        next_o = we_i ? wdata_i : cur_i;
    end
endmodule

// File: rtl/fpx_trap_reduce.sv
// Collapses a cause vector into a single trap request.
module fpx_trap_reduce #(
    parameter int unsigned WIDTH = 5
) (
    input  logic [WIDTH-1:0] cause_i,
    output logic             trap_o
);
    always_comb begin
        trap_o = |cause_i;
    end
endmodule

// File: rtl/fpx_status_unit.sv
module fpx_status_unit
    import fpx_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                op_done_i,
    input  logic [FPX_NCLS-1:0] raw_evt_i,
    input  logic                en_we_i,
    input  logic [FPX_NCLS-1:0] en_wdata_i,
    output logic [FPX_NCLS-1:0] flags_o,
    output logic [FPX_NCLS-1:0] cause_o,
    output logic [FPX_NCLS-1:0] enables_o,
    output logic                trap_req_o
);
    localparam int unsigned NCLS = FPX_NCLS;

    fpx_state_t state_d, state_q;

    fpx_vec_t new_flags;
    fpx_vec_t new_cause;
    fpx_vec_t en_next;
    logic     new_trap;

    // Per-class decode, always against the enable value held before any same-cycle write.
    for (genvar c = 0; c < NCLS; c++) begin : g_cls
        fpx_class_slice u_slice (
            .evt_i   (raw_evt_i[c]),
            .en_i    (state_q.enables[c]),
            .flag_o  (new_flags[c]),
            .cause_o (new_cause[c])
        );
    end

    fpx_enable_next #(.WIDTH(NCLS)) u_en_next (
        .we_i    (en_we_i),
        .wdata_i (en_wdata_i),
        .cur_i   (state_q.enables),
        .next_o  (en_next)
    );

    fpx_trap_reduce #(.WIDTH(NCLS)) u_trap (
        .cause_i (new_cause),
        .trap_o  (new_trap)
    );

    always_comb begin
        state_d         = state_q;
        state_d.enables = en_next;
        if (op_done_i) begin
            state_d.flags = new_flags;
            state_d.cause = new_cause;
            state_d.trap  = new_trap;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign flags_o    = state_q.flags;
    assign cause_o    = state_q.cause;
    assign enables_o  = state_q.enables;
    assign trap_req_o = state_q.trap;

endmodule

// File: rtl/fpx_status_unit_chk.sv
module fpx_status_unit_chk #(
    parameter int unsigned W = 5
) (
    input logic         clk,
    input logic         rst_n,
    input logic         op_done_i,
    input logic [W-1:0] raw_evt_i,
    input logic         en_we_i,
    input logic [W-1:0] en_wdata_i,
    input logic [W-1:0] flags_o,
    input logic [W-1:0] cause_o,
    input logic [W-1:0] enables_o,
    input logic         trap_req_o
);
    assert_flags_written_R2: assert property (@(posedge clk) disable iff (!rst_n)
        op_done_i |=> flags_o == $past(raw_evt_i));

    assert_cause_masked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        op_done_i |=> cause_o == ($past(raw_evt_i) & $past(enables_o)));

    assert_cause_within_flags_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_o & ~flags_o) == '0);

    assert_hold_when_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !op_done_i |=> $stable(flags_o) && $stable(cause_o));

    assert_trap_tracks_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        op_done_i |=> trap_req_o == (($past(raw_evt_i) & $past(enables_o)) != '0));

    assert_enable_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        en_we_i |=> enables_o == $past(en_wdata_i));

    assert_enable_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !en_we_i |=> $stable(enables_o));
endmodule

bind fpx_status_unit fpx_status_unit_chk #(.W(fpx_pkg::FPX_NCLS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_done_i  (op_done_i),
    .raw_evt_i  (raw_evt_i),
    .en_we_i    (en_we_i),
    .en_wdata_i (en_wdata_i),
    .flags_o    (flags_o),
    .cause_o    (cause_o),
    .enables_o  (enables_o),
    .trap_req_o (trap_req_o)
);

// File: tb/fpx_status_unit_tb.sv
`timescale 1ns/1ps
module fpx_status_unit_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_done_i = 1'b0;
    logic [4:0] raw_evt_i = '0;
    logic       en_we_i = 1'b0;
    logic [4:0] en_wdata_i = '0;
    logic [4:0] flags_o, cause_o, enables_o;
    logic       trap_req_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [4:0] en_model = '0;

    always #2 clk = ~clk;

    fpx_status_unit u_dut (
        .clk(clk), .rst_n(rst_n), .op_done_i(op_done_i), .raw_evt_i(raw_evt_i),
        .en_we_i(en_we_i), .en_wdata_i(en_wdata_i), .flags_o(flags_o),
        .cause_o(cause_o), .enables_o(enables_o), .trap_req_o(trap_req_o)
    );

    task automatic chk(input string req, input string what, input logic [4:0] act, input logic [4:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic chk_all(input string req, input logic [4:0] ef, input logic [4:0] ec);
        chk(req, "flags", flags_o, ef);
        chk(req, "cause", cause_o, ec);
        chk(req, "enables", enables_o, en_model);
        chk(req, "trap", {4'b0, trap_req_o}, {4'b0, (ec != 5'b0)});
    endtask

    task automatic write_en(input logic [4:0] v);
        @(negedge clk);
        en_we_i = 1'b1; en_wdata_i = v;
        @(negedge clk);
        en_we_i = 1'b0;
        en_model = v;
        chk("R7", "enable write", enables_o, v);
    endtask

    task automatic do_op(input string req, input logic [4:0] raw);
        @(negedge clk);
        op_done_i = 1'b1; raw_evt_i = raw;
        @(negedge clk);
        op_done_i = 1'b0; raw_evt_i = '0;
        chk_all(req, raw, raw & en_model);
    endtask

    task automatic t_reset;
        chk_all("R1", 5'b0, 5'b0);
    endtask

    task automatic t_flags_ignore_enables;
        en_model = 5'b0;
        for (int c = 0; c < 5; c++) do_op("R2", 5'b1 << c);
        do_op("R2", 5'b11111);
    endtask

    task automatic t_cause_masking;
        write_en(5'b10100);
        do_op("R3", 5'b11111);
        do_op("R3", 5'b01011);
        do_op("R6", 5'b00100);
        write_en(5'b11111);
        for (int c = 0; c < 5; c++) do_op("R3", 5'b1 << c);
    endtask

    task automatic t_no_events;
        do_op("R4", 5'b11011);
        do_op("R4", 5'b00000);
    endtask

    task automatic t_idle_hold;
        do_op("R5", 5'b10010);
        repeat (3) begin
            @(negedge clk);
            raw_evt_i = 5'b01101;
        end
        @(negedge clk);
        raw_evt_i = '0;
        chk_all("R5", 5'b10010, 5'b10010 & en_model);
    endtask

    task automatic t_enable_owned;
        write_en(5'b01001);
        do_op("R7", 5'b11111);
        chk("R7", "enables after op", enables_o, 5'b01001);
    endtask

    task automatic t_same_cycle;
        logic [4:0] old_en;
        old_en = en_model;
        @(negedge clk);
        op_done_i = 1'b1; raw_evt_i = 5'b11111;
        en_we_i = 1'b1; en_wdata_i = 5'b10000;
        @(negedge clk);
        op_done_i = 1'b0; en_we_i = 1'b0; raw_evt_i = '0;
        en_model = 5'b10000;
        chk_all("R8", 5'b11111, 5'b11111 & old_en);
    endtask

    task automatic t_overwrite;
        write_en(5'b11111);
        do_op("R9", 5'b11000);
        do_op("R9", 5'b00011);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_flags_ignore_enables();
        t_cause_masking();
        t_no_events();
        t_idle_hold();
        t_enable_owned();
        t_same_cycle();
        t_overwrite();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #40000;
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule